// File: doc/BRIEF.md
# Paged ROM Table Lookup Sequencer

This block carries out the table-read instruction of a small 4-bit controller. When the instruction `0_1001_0ppp` is presented while the sequencer is idle, it saves the current program counter on a shared hardware return stack. It then points the program counter at a data word in ROM. The upper three address bits come from the page operand `ppp`, the middle three from register D, and the low four from accumulator A. The block reads the 9-bit word through a synchronous ROM port with one cycle of latency and hands its low nibble to A and its next nibble to B through write strobes. If a sticky mode flag has been set, it also passes bit 8 of the word to the carry flag. Finally it pops the stack to restore the program counter. The lookup therefore holds one stack level only while it runs.

The same stack also serves subroutine calls and returns from the fetch unit through push and pop requests that are honoured only while the sequencer is idle. Starting a lookup, or pushing, when every level is occupied raises a sticky overflow flag. In that case the lookup is abandoned after a single cycle and no register write is issued.

Top module: `table_lookup_seq`

## Requirements
- R1: A lookup starts only when `instr_valid` is high, `busy` is low and `instr[8:3]` equals `6'b010010`. Any other code, or any instruction offered while `busy` is high, is ignored. After an accepted start, `busy` reads high from the next cycle on.
- R2: In the cycle after a start, the PC captured with the instruction is written to the stack. From the following cycle on, `sp_o` is one higher and `top_o` shows that PC.
- R3: Two cycles after the start, `rom_re` is high for exactly one cycle. In that cycle `rom_addr` equals `{instr[2:0], d_i, a_i}` as sampled at the start, with the page in bits 9:7, D in bits 6:4 and A in bits 3:0. `pc_o` shows the same value.
- R4: In the cycle after the ROM read, `a_we` and `b_we` are high for one cycle, with `a_wdata = rom_rdata[3:0]` and `b_wdata = rom_rdata[7:4]`.
- R5: In that same cycle `cy_we` is high, with `cy_wdata = rom_rdata[8]`, only if the mode flag is set. Otherwise `cy_we` stays low.
- R6: A one-cycle `mode_set` pulse sets the mode flag. The flag then stays set for every later lookup until reset.
- R7: `done` is high for one cycle, in the fourth cycle after the start. One cycle later `busy` is low, `sp_o` is back to its value before the start, and `pc_o` equals the saved PC.
- R8: A start while `sp_o` equals DEPTH sets `ovf`, which stays high until reset. `done` then pulses in the next cycle, and no ROM read, no register write and no stack change take place.
- R9: While idle and with no lookup starting, `call_push` pushes `pc_i` and `ret_pop` pops, and `top_o` always shows the newest entry. A push when full is dropped and sets `ovf`. A pop when empty is dropped. Both requests are ignored in the start cycle and while busy.
- R10: After reset, `busy`, `done`, `rom_re`, all write strobes and `ovf` are low, and `sp_o` and `pc_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction offered by fetch |
| instr | input | 9 | Instruction word |
| pc_i | input | 10 | Current program counter (return address) |
| d_i | input | 3 | Register D |
| a_i | input | 4 | Accumulator A |
| mode_set | input | 1 | Sets the sticky carry-load mode flag |
| call_push | input | 1 | Fetch request to push `pc_i` |
| ret_pop | input | 1 | Fetch request to pop the stack |
| rom_re | output | 1 | ROM read enable |
| rom_addr | output | 10 | ROM read address |
| rom_rdata | input | 9 | ROM data, valid one cycle after `rom_re` |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | Final cycle of a lookup or abort |
| a_we | output | 1 | Write strobe for A |
| a_wdata | output | 4 | Data for A |
| b_we | output | 1 | Write strobe for B |
| b_wdata | output | 4 | Data for B |
| cy_we | output | 1 | Write strobe for carry |
| cy_wdata | output | 1 | Data for carry |
| pc_o | output | 10 | Program counter held by the sequencer |
| sp_o | output | 4 | Stack pointer |
| top_o | output | 10 | Newest stack entry (0 when empty) |
| ovf | output | 1 | Sticky stack overflow flag |

## Verification
Two functions compete for the stack in the same cycle: a lookup start and a push request from the fetch unit. A pop request can also arrive while a lookup holds its borrowed level. The bench raises `call_push` in the very cycle that offers the lookup instruction, and raises `ret_pop` in the cycle the lookup pushes its return address. It then checks that the stack pointer moves by exactly one during the lookup and comes back to its starting value, and that the restored PC is the one captured with the instruction. A third collision, a start when the stack is full, is judged by the overflow flag, the one-cycle `done` and the absence of any write strobe.

// File: rtl/tls_pkg.sv
package tls_pkg;
  localparam int INSTR_W = 9;
  localparam int PAGE_W  = 3;
  localparam int D_W     = 3;
  localparam int A_W     = 4;
  localparam int ROM_W   = 9;
  localparam int PC_W    = PAGE_W + D_W + A_W;
  localparam logic [INSTR_W-PAGE_W-1:0] LOOKUP_OPC = 6'b010010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH, ST_READ, ST_CAPT, ST_POP, ST_FAULT
  } tls_state_e;

  function automatic logic is_lookup(input logic [INSTR_W-1:0] ins);
    return ins[INSTR_W-1:PAGE_W] == LOOKUP_OPC;
  endfunction

  function automatic logic [PC_W-1:0] form_addr(input logic [PAGE_W-1:0] pg,
                                                input logic [D_W-1:0] d,
                                                input logic [A_W-1:0] a);
    return {pg, d, a};
  endfunction
endpackage

// File: rtl/tls_stack.sv
module tls_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 10,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [W-1:0]    wdata,
  output logic [SP_W-1:0] sp,
  output logic            full,
  output logic            empty,
  output logic [W-1:0]    top
);
  localparam logic [SP_W-1:0] ONE = 1;
  localparam logic [SP_W-1:0] LIM = SP_W'(DEPTH);

  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] sp_m1;

  assign sp_m1 = sp_q - ONE;
  assign sp    = sp_q;
  assign full  = (sp_q == LIM);
  assign empty = (sp_q == '0);
  assign top   = empty ? '0 : mem[sp_m1[IDX_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             sp_q <= '0;
    else if (push && !full) sp_q <= sp_q + ONE;
    else if (pop && !empty) sp_q <= sp_m1;
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[sp_q[IDX_W-1:0]] <= wdata;
  end

  AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> sp == $past(sp) + ONE);  // R2
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> sp == $past(sp) - ONE);  // R9
  AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= LIM);  // R8
endmodule

// File: rtl/tls_addr_gen.sv
module tls_addr_gen
  import tls_pkg::*;
(
  input  logic [PAGE_W-1:0] page,
  input  logic [D_W-1:0]    d,
  input  logic [A_W-1:0]    a,
  output logic [PC_W-1:0]   addr
);
  assign addr = form_addr(page, d, a);
endmodule

// File: rtl/table_lookup_seq.sv
module table_lookup_seq
  import tls_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [D_W-1:0]     d_i,
  input  logic [A_W-1:0]     a_i,
  input  logic               mode_set,
  input  logic               call_push,
  input  logic               ret_pop,
  output logic               rom_re,
  output logic [PC_W-1:0]    rom_addr,
  input  logic [ROM_W-1:0]   rom_rdata,
  output logic               busy,
  output logic               done,
  output logic               a_we,
  output logic [A_W-1:0]     a_wdata,
  output logic               b_we,
  output logic [A_W-1:0]     b_wdata,
  output logic               cy_we,
  output logic               cy_wdata,
  output logic [PC_W-1:0]    pc_o,
  output logic [SP_W-1:0]    sp_o,
  output logic [PC_W-1:0]    top_o,
  output logic               ovf
);
  tls_state_e state_q, state_d;

  logic [PAGE_W-1:0] page_q;
  logic [D_W-1:0]    d_q;
  logic [A_W-1:0]    a_q;
  logic [PC_W-1:0]   pc_save_q, pc_q, look_addr, stk_wdata;
  logic              mode_q, ovf_q;
  logic              stk_full, stk_empty;

  // named events for the checks
  logic idle, start_ev, abort_ev, ext_push_ev, ext_pop_ev, push_ev, pop_ev;

  assign idle        = (state_q == ST_IDLE);
  assign start_ev    = idle && instr_valid && is_lookup(instr);
  assign abort_ev    = start_ev && stk_full;
  assign ext_push_ev = idle && !start_ev && call_push;
  assign ext_pop_ev  = idle && !start_ev && ret_pop;
  assign push_ev     = (state_q == ST_PUSH) || ext_push_ev;
  assign pop_ev      = (state_q == ST_POP) || ext_pop_ev;
  assign stk_wdata   = (state_q == ST_PUSH) ? pc_save_q : pc_i;

  tls_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push_ev), .pop(pop_ev), .wdata(stk_wdata),
    .sp(sp_o), .full(stk_full), .empty(stk_empty), .top(top_o)
  );

  tls_addr_gen u_addr (.page(page_q), .d(d_q), .a(a_q), .addr(look_addr));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_ev) state_d = abort_ev ? ST_FAULT : ST_PUSH;
      ST_PUSH:  state_d = ST_READ;
      ST_READ:  state_d = ST_CAPT;
      ST_CAPT:  state_d = ST_POP;
      ST_POP:   state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      page_q    <= '0;
      d_q       <= '0;
      a_q       <= '0;
      pc_save_q <= '0;
      pc_q      <= '0;
      mode_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (mode_set) mode_q <= 1'b1;
      if (abort_ev || (ext_push_ev && stk_full)) ovf_q <= 1'b1;
      if (start_ev) begin
        page_q    <= instr[PAGE_W-1:0];
        d_q       <= d_i;
        a_q       <= a_i;
        pc_save_q <= pc_i;
      end
      if (state_q == ST_PUSH) pc_q <= look_addr;
      else if (state_q == ST_POP) pc_q <= top_o;
    end
  end

  assign busy     = !idle;
  assign done     = (state_q == ST_POP) || (state_q == ST_FAULT);
  assign rom_re   = (state_q == ST_READ);
  assign rom_addr = pc_q;
  assign pc_o     = pc_q;
  assign a_we     = (state_q == ST_CAPT);
  assign b_we     = (state_q == ST_CAPT);
  assign cy_we    = (state_q == ST_CAPT) && mode_q;
  assign a_wdata  = rom_rdata[A_W-1:0];
  assign b_wdata  = rom_rdata[2*A_W-1:A_W];
  assign cy_wdata = rom_rdata[ROM_W-1];
  assign ovf      = ovf_q;

  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    rom_re |-> rom_addr == {$past(instr[PAGE_W-1:0], 2), $past(d_i, 2), $past(a_i, 2)});  // R3
  AST_CAPT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |-> $past(rom_re));  // R4
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> mode_q);  // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);  // R8
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (done && !a_we && !rom_re && $stable(sp_o)));  // R8
  AST_PHASES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_re, a_we, done}));  // R7
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);  // R7
  AST_NO_EXT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(state_q == ST_PUSH) && !(state_q == ST_POP)) |=> $stable(sp_o));  // R9
endmodule

// File: tb/test_table_lookup_seq.sv
module test_table_lookup_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instr_valid = 1'b0;
  logic [8:0] instr = '0;
  logic [9:0] pc_i = '0;
  logic [2:0] d_i = '0;
  logic [3:0] a_i = '0;
  logic       mode_set = 1'b0, call_push = 1'b0, ret_pop = 1'b0;
  logic       rom_re;
  logic [9:0] rom_addr;
  logic [8:0] rom_rdata = '0;
  logic       busy, done, a_we, b_we, cy_we, cy_wdata, ovf;
  logic [3:0] a_wdata, b_wdata, sp_o;
  logic [9:0] pc_o, top_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  table_lookup_seq i_table_lookup_seq (.*);

  function automatic logic [8:0] rom_fn(input logic [9:0] ad);
    return 9'((ad * 53 + 17) ^ (ad >> 3));
  endfunction

  always @(posedge clk) if (rom_re) rom_rdata <= rom_fn(rom_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(!busy && !done && !rom_re, "R10 idle outputs", {busy, done, rom_re}, 0);
    chk(!a_we && !b_we && !cy_we && !ovf, "R10 strobes/ovf", {a_we, b_we, cy_we, ovf}, 0);
    chk(sp_o == 0 && pc_o == 0, "R10 sp/pc", {sp_o, pc_o}, 0);
  endtask

  // full lookup; collide raises call_push at start and ret_pop while busy
  task automatic t_lookup(input logic [2:0] p, input logic [2:0] d, input logic [3:0] a,
                          input logic [9:0] pc, input bit exp_cy, input bit collide);
    logic [3:0] sp0;
    logic [9:0] ad;
    logic [8:0] w;
    ad = {p, d, a};
    w = rom_fn(ad);
    sp0 = sp_o;
    instr_valid = 1'b1; instr = {6'b010010, p}; pc_i = pc; d_i = d; a_i = a;
    call_push = collide;
    @(negedge clk);
    instr_valid = 1'b0; call_push = 1'b0; ret_pop = collide;
    pc_i = ~pc; d_i = ~d; a_i = ~a;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    chk(rom_re == 1'b0, "R3 no read in push cycle", rom_re, 0);
    @(negedge clk);
    ret_pop = 1'b0;
    chk(rom_re == 1'b1 && rom_addr == ad, "R3 rom address", rom_addr, ad);
    chk(pc_o == ad, "R3 pc redirected", pc_o, ad);
    chk(sp_o == sp0 + 4'd1, "R2 sp incremented", sp_o, sp0 + 4'd1);
    chk(top_o == pc, "R2 pushed pc", top_o, pc);
    @(negedge clk);
    chk(a_we && a_wdata == w[3:0], "R4 A write", {a_we, a_wdata}, {1'b1, w[3:0]});
    chk(b_we && b_wdata == w[7:4], "R4 B write", {b_we, b_wdata}, {1'b1, w[7:4]});
    chk(cy_we == exp_cy, "R5 carry strobe", cy_we, exp_cy);
    if (exp_cy) chk(cy_wdata == w[8], "R5 carry data", cy_wdata, w[8]);
    chk(done == 1'b0, "R7 done not early", done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R7 done pulse", done, 1);
    @(negedge clk);
    chk(!done && !busy, "R7 released", {done, busy}, 0);
    chk(pc_o == pc, "R7 pc restored", pc_o, pc);
    chk(sp_o == sp0, "R7 sp restored", sp_o, sp0);
  endtask

  task automatic t_ignore();
    instr_valid = 1'b1; instr = 9'b0_1001_1010; pc_i = 10'h155;
    @(negedge clk);
    chk(!busy && sp_o == 0, "R1 near code ignored", {busy, sp_o}, 0);
    instr = 9'b1_1001_0010;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(!busy && sp_o == 0, "R1 bit8 code ignored", {busy, sp_o}, 0);
    // start, then offer another lookup while busy
    instr_valid = 1'b1; instr = 9'b0_1001_0001; pc_i = 10'h0AA; d_i = 3'd2; a_i = 4'd5;
    @(negedge clk);
    instr = 9'b0_1001_0110; d_i = 3'd7; a_i = 4'd1;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(rom_addr == {3'd1, 3'd2, 4'd5}, "R1 busy start ignored", rom_addr, {3'd1, 3'd2, 4'd5});
    repeat (3) @(negedge clk);
    chk(!busy && sp_o == 0 && pc_o == 10'h0AA, "R1 no second lookup", {busy, sp_o}, 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 8; i++) begin
      call_push = 1'b1; pc_i = 10'(16 * i + 3);
      @(negedge clk);
    end
    call_push = 1'b0;
    chk(sp_o == 4'd8 && top_o == 10'(16 * 7 + 3), "R9 pushes", sp_o, 8);
    chk(ovf == 1'b0, "R8 no ovf yet", ovf, 0);
    instr_valid = 1'b1; instr = 9'b0_1001_0011; pc_i = 10'h3FF;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(ovf && done, "R8 abort done+ovf", {ovf, done}, 3);
    chk(!a_we && !b_we && !cy_we && !rom_re, "R8 no writes", {a_we, b_we, cy_we, rom_re}, 0);
    chk(sp_o == 4'd8, "R8 sp kept", sp_o, 8);
    @(negedge clk);
    chk(!busy && !done, "R8 back idle", {busy, done}, 0);
    call_push = 1'b1; pc_i = 10'h222;
    @(negedge clk);
    call_push = 1'b0;
    chk(sp_o == 4'd8 && top_o == 10'(16 * 7 + 3), "R9 push when full dropped", top_o, 16 * 7 + 3);
    for (int i = 7; i >= 0; i--) begin
      chk(top_o == 10'(16 * i + 3), "R9 LIFO order", top_o, 16 * i + 3);
      ret_pop = 1'b1;
      @(negedge clk);
    end
    @(negedge clk);
    ret_pop = 1'b0;
    chk(sp_o == 0 && top_o == 0, "R9 pop when empty", {sp_o, top_o}, 0);
    chk(ovf == 1'b1, "R8 ovf sticky", ovf, 1);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_lookup(3'd5, 3'd3, 4'hA, 10'h1C7, 1'b0, 1'b0);  // mode clear: R5 no carry
    t_lookup(3'd0, 3'd0, 4'h0, 10'h3FF, 1'b0, 1'b0);
    t_ignore();
    call_push = 1'b1; pc_i = 10'h0F0;
    @(negedge clk);
    call_push = 1'b0;
    t_lookup(3'd7, 3'd7, 4'hF, 10'h2A5, 1'b0, 1'b0);  // nested over a call
    chk(top_o == 10'h0F0, "R9 call entry kept", top_o, 10'h0F0);
    ret_pop = 1'b1;
    @(negedge clk);
    ret_pop = 1'b0;
    t_lookup(3'd2, 3'd6, 4'h9, 10'h111, 1'b0, 1'b1);  // collision
    mode_set = 1'b1;
    @(negedge clk);
    mode_set = 1'b0;
    for (int k = 0; k < 4; k++) t_lookup(3'(k + 1), 3'(k * 3), 4'(k * 5 + 2), 10'(k * 97 + 9), 1'b1, 1'b0);  // R6
    t_overflow();
    do_reset();
    chk(ovf == 1'b0 && sp_o == 0, "R10 reset clears ovf", ovf, 0);
    t_lookup(3'd4, 3'd1, 4'h3, 10'h050, 1'b0, 1'b0);  // R6 cleared by reset
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule